// File: doc/BRIEF.md
# Coprocessor Data-Operation Dispatcher

This block watches a processor's instruction stream and routes coprocessor data-operation words to up to sixteen coprocessor slots. Each word arrives with a valid strobe and a condition-passed flag that the processor has already evaluated. A word whose class bits mark it as a data operation, and whose condition passed, is checked against a presence mask. If the numbered coprocessor is present, the word goes into that slot's own queue. Issue is fire-and-forget: nothing comes back to the processor and it never waits for an operation to finish.

A word that names a coprocessor the mask marks absent raises an undefined-instruction trap. The trap is a registered one-cycle pulse that carries the offending word for the handler. Each slot holds a stub coprocessor that drains its queue at a fixed slow rate. The stub reports how many operations it has completed and the last word it retired, so the overlap between issue and execution can be observed. The only time issue is held back is when the target queue is full. In that case a same-cycle stall tells the source to present the word again, and the word is never dropped.

Top module: `cop_dispatch`

## Requirements
- R1: A word is a data operation only when bits 27:24 are 4'b1110 and bit 4 is 0. Any other word causes no trap, no stall and no queue entry.
- R2: A data operation presented with `cond_pass` low is dropped: no trap, no stall, no queue entry.
- R3: An accepted operation enters only the queue of the coprocessor numbered in bits 11:8. The completed counts of all other slots stay unchanged.
- R4: A passing data operation whose number has a 0 in `cp_present` raises a trap instead of being queued. With the mask all zero, every passing data operation traps.
- R5: `trap_pulse` is high for exactly the one cycle after the clock edge that samples the offending word, and only for such a word.
- R6: `trap_word` holds the full 32-bit offending word while `trap_pulse` is high.
- R7: Each queue holds 4 entries. While a passing data operation targets a present slot whose queue is full, `issue_stall` is high in that same cycle and the word is not taken. The source keeps presenting the word until it is accepted, so no operation is lost. With back-to-back issue into one empty queue, 8 operations incur 6 stall cycles in total.
- R8: A stub pops its head entry after 3 clock edges of non-empty occupancy, and increments its 16-bit completed count by one per pop. An operation pushed into an empty queue at edge E is counted after edge E+3.
- R9: The 32-bit `last_done_word` slice of a slot equals the complete, unaltered word of the most recently completed operation in that slot.
- R10: An operation aimed at a queue that is not full never stalls, even while other queues are busy.
- R11: After reset every count and last word is zero and `trap_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is presented this cycle |
| instr_word | input | 32 | Instruction word |
| cond_pass | input | 1 | The word's condition evaluated true |
| cp_present | input | NUM_CP | One bit per implemented coprocessor number |
| issue_stall | output | 1 | Target queue full; hold the word (same cycle) |
| trap_pulse | output | 1 | Undefined-instruction trap, one cycle |
| trap_word | output | 32 | Word that caused the trap |
| done_count | output | NUM_CP*16 | Completed count per slot, slot n at bits 16n+15:16n |
| last_done_word | output | NUM_CP*32 | Last retired word per slot, slot n at bits 32n+31:32n |

## Verification
A push and a pop on the same queue can fall in the same cycle. So can a queue that fills in one cycle and frees an entry at the next drain edge. Both are provoked by driving eight operations back-to-back at a single slot. The occupancy then climbs, holds where a push meets a pop, and reaches full. The resulting stall cycles are counted against the figure worked out from the 3-cycle drain period, and the completed count must still reach all eight.

// File: rtl/cdp_pkg.sv
package cdp_pkg;
  localparam int WORD_W = 32;
  localparam int CPN_W  = 4;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CPN_W-1:0]  cpn_t;

  // class bits and the bit that separates data operations from transfers
  function automatic logic is_data_op(input word_t w);
    return (w[27:24] == 4'b1110) && !w[4];
  endfunction

  function automatic cpn_t cp_number(input word_t w);
    return w[11:8];
  endfunction
endpackage

// File: rtl/cdp_decode.sv
module cdp_decode
  import cdp_pkg::*;
#(
  parameter int NUM_CP = 16
) (
  input  logic              instr_valid,
  input  word_t             instr_word,
  input  logic              cond_pass,
  input  logic [NUM_CP-1:0] cp_present,
  input  logic [NUM_CP-1:0] q_full,
  output logic [NUM_CP-1:0] push,
  output logic              stall,
  output logic              unclaimed
);
  localparam int SLOTS = 1 << CPN_W;

  logic [SLOTS-1:0] mask_ext, full_ext;
  logic             live, claimed;
  cpn_t             num;

  always_comb begin
    mask_ext = '0;
    full_ext = '0;
    mask_ext[NUM_CP-1:0] = cp_present;
    full_ext[NUM_CP-1:0] = q_full;
    num       = cp_number(instr_word);
    live      = instr_valid && cond_pass && is_data_op(instr_word);
    claimed   = live && mask_ext[num];
    unclaimed = live && !mask_ext[num];
    stall     = claimed && full_ext[num];
  end

  for (genvar i = 0; i < NUM_CP; i++) begin : g_sel
    assign push[i] = claimed && (num == cpn_t'(i)) && !q_full[i];
  end
endmodule

// File: rtl/cdp_stub_cp.sv
module cdp_stub_cp
  import cdp_pkg::*;
#(
  parameter int DEPTH        = 4,
  parameter int DRAIN_CYCLES = 3,
  parameter int CNT_W        = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  word_t            push_word,
  output logic             full,
  output logic [CNT_W-1:0] done_count,
  output word_t            last_word
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int TW = (DRAIN_CYCLES > 1) ? $clog2(DRAIN_CYCLES) : 1;

  word_t         mem [DEPTH];
  logic [AW:0]   wr_ptr, rd_ptr;
  logic [TW-1:0] tick;
  logic          empty, pop;

  assign empty = (wr_ptr == rd_ptr);
  assign full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign pop   = !empty && (tick == TW'(DRAIN_CYCLES - 1));

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr[AW-1:0]] <= push_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      tick       <= '0;
      done_count <= '0;
      last_word  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop) begin
        rd_ptr     <= rd_ptr + 1'b1;
        done_count <= done_count + 1'b1;
        last_word  <= mem[rd_ptr[AW-1:0]];
      end
      if (empty || pop) tick <= '0;
      else              tick <= tick + 1'b1;
    end
  end
endmodule

// File: rtl/cop_dispatch.sv
module cop_dispatch #(
  parameter int NUM_CP       = 16,
  parameter int QDEPTH       = 4,
  parameter int DRAIN_CYCLES = 3,
  parameter int CNT_W        = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    instr_valid,
  input  logic [31:0]             instr_word,
  input  logic                    cond_pass,
  input  logic [NUM_CP-1:0]       cp_present,
  output logic                    issue_stall,
  output logic                    trap_pulse,
  output logic [31:0]             trap_word,
  output logic [NUM_CP*CNT_W-1:0] done_count,
  output logic [NUM_CP*32-1:0]    last_done_word
);
  logic [NUM_CP-1:0] push, q_full;
  logic              unclaimed;

  cdp_decode #(.NUM_CP(NUM_CP)) i_decode (
    .instr_valid (instr_valid),
    .instr_word  (instr_word),
    .cond_pass   (cond_pass),
    .cp_present  (cp_present),
    .q_full      (q_full),
    .push        (push),
    .stall       (issue_stall),
    .unclaimed   (unclaimed)
  );

  for (genvar i = 0; i < NUM_CP; i++) begin : g_cp
    cdp_stub_cp #(
      .DEPTH        (QDEPTH),
      .DRAIN_CYCLES (DRAIN_CYCLES),
      .CNT_W        (CNT_W)
    ) i_stub (
      .clk        (clk),
      .rst        (rst),
      .push       (push[i]),
      .push_word  (instr_word),
      .full       (q_full[i]),
      .done_count (done_count[i*CNT_W +: CNT_W]),
      .last_word  (last_done_word[i*32 +: 32])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_pulse <= 1'b0;
      trap_word  <= '0;
    end else begin
      trap_pulse <= unclaimed;
      if (unclaimed) trap_word <= instr_word;
    end
  end
endmodule

// File: rtl/cop_dispatch_chk.sv
module cop_dispatch_chk #(
  parameter int NUM_CP = 16,
  parameter int CNT_W  = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    instr_valid,
  input logic [31:0]             instr_word,
  input logic                    cond_pass,
  input logic [NUM_CP-1:0]       cp_present,
  input logic                    issue_stall,
  input logic                    trap_pulse,
  input logic [31:0]             trap_word,
  input logic [NUM_CP*CNT_W-1:0] done_count,
  input logic [NUM_CP*32-1:0]    last_done_word
);
  logic [15:0] mask16;
  assign mask16 = 16'(cp_present);

  p_trap_source_r5: assert property (@(posedge clk) disable iff (rst)
    trap_pulse |-> $past(instr_valid && cond_pass && instr_word[27:24] == 4'b1110 && !instr_word[4]));

  p_trap_word_r6: assert property (@(posedge clk) disable iff (rst)
    trap_pulse |-> (trap_word == $past(instr_word)));

  p_trap_absent_r4: assert property (@(posedge clk) disable iff (rst)
    trap_pulse |-> !$past(mask16[instr_word[11:8]]));

  p_stall_dataop_r1: assert property (@(posedge clk) disable iff (rst)
    issue_stall |-> (instr_word[27:24] == 4'b1110 && !instr_word[4] && cond_pass));

  for (genvar i = 0; i < NUM_CP; i++) begin : g_cnt
    p_count_step_r8: assert property (@(posedge clk) disable iff (rst)
      $past(!rst) |->
      ((done_count[i*CNT_W +: CNT_W] == $past(done_count[i*CNT_W +: CNT_W])) ||
       (done_count[i*CNT_W +: CNT_W] == CNT_W'($past(done_count[i*CNT_W +: CNT_W]) + 1))));
  end
endmodule

bind cop_dispatch cop_dispatch_chk #(.NUM_CP(NUM_CP), .CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_cop_dispatch.sv
module test_cop_dispatch;
  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          instr_valid = 1'b0;
  logic [31:0]   instr_word = '0;
  logic          cond_pass = 1'b0;
  logic [15:0]   cp_present = '0;
  logic          issue_stall, trap_pulse;
  logic [31:0]   trap_word;
  logic [255:0]  done_count;
  logic [511:0]  last_done_word;

  int checks = 0;
  int errors = 0;
  int exp_cnt [16];
  logic [31:0] exp_last [16];

  always #2.5 clk = ~clk;

  cop_dispatch i_cop_dispatch (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .cond_pass(cond_pass), .cp_present(cp_present), .issue_stall(issue_stall),
    .trap_pulse(trap_pulse), .trap_word(trap_word), .done_count(done_count),
    .last_done_word(last_done_word)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int cpn, input int seed, input bit cls_ok);
    logic [31:0] w;
    w = {4'(seed * 3 + 1), cls_ok ? 4'b1110 : 4'b1100, 4'(seed + 5), 4'(seed * 7),
         4'(seed ^ 9), 4'(cpn), 3'(seed + 2), 1'b0, 4'(seed * 5 + 3)};
    return w;
  endfunction

  function automatic int cnt_of(input int n);
    return int'(done_count[n*16 +: 16]);
  endfunction

  // presents one word, waits out stalls, returns trap seen after the capture edge
  task automatic issue(input logic [31:0] w, input bit cp, output int stalls,
                       output bit tr, output logic [31:0] tw);
    @(negedge clk);
    instr_word = w; cond_pass = cp; instr_valid = 1'b1; stalls = 0;
    #1;
    while (issue_stall) begin stalls++; @(negedge clk); #1; end
    @(negedge clk);
    tr = trap_pulse; tw = trap_word;
    instr_valid = 1'b0;
  endtask

  task automatic burst(input logic [31:0] ws [8], input int n, output int stalls);
    stalls = 0;
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      instr_word = ws[k]; cond_pass = 1'b1; instr_valid = 1'b1;
      #1;
      while (issue_stall) begin stalls++; @(negedge clk); #1; end
      @(negedge clk);
    end
    instr_valid = 1'b0;
  endtask

  task automatic settle_and_compare(input string tag);
    repeat (40) @(negedge clk);
    for (int n = 0; n < 16; n++) begin
      chk(cnt_of(n) == exp_cnt[n], "R3", {tag, " count"}, cnt_of(n), exp_cnt[n]);
      chk(last_done_word[n*32 +: 32] == exp_last[n], "R9", {tag, " last word"},
          last_done_word[n*32 +: 32], exp_last[n]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int st, c0;
    bit tr;
    logic [31:0] tw, w;
    logic [31:0] ws [8];
    for (int n = 0; n < 16; n++) begin exp_cnt[n] = 0; exp_last[n] = '0; end

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(trap_pulse == 1'b0, "R11", "trap after reset", trap_pulse, 0);
    chk(done_count == '0, "R11", "counts after reset", done_count[63:0], 0);
    chk(last_done_word == '0, "R11", "last words after reset", last_done_word[63:0], 0);

    // sweep every coprocessor number with and without condition (R2 R3 R4 R5 R6)
    cp_present = 16'hA5C3;
    for (int n = 0; n < 16; n++) begin
      for (int c = 0; c < 2; c++) begin
        w = mk(n, n + c, 1'b1);
        issue(w, c[0], st, tr, tw);
        if (c == 0) begin
          chk(!tr, "R2", "failed condition trapped", tr, 0);
        end else if (cp_present[n]) begin
          chk(!tr, "R4", "present slot trapped", tr, 0);
          chk(st == 0, "R10", "stall on idle queue", st, 0);
          exp_cnt[n]++; exp_last[n] = w;
        end else begin
          chk(tr, "R4", "absent slot did not trap", tr, 1);
          chk(tw == w, "R6", "trap word", tw, w);
          @(negedge clk);
          chk(!trap_pulse, "R5", "trap longer than one cycle", trap_pulse, 0);
        end
      end
    end
    settle_and_compare("sweep");

    // class-bit and bit-4 sweep: present slot 0, absent slot 2 (R1)
    for (int cls = 0; cls < 16; cls++) begin
      for (int b4 = 0; b4 < 2; b4++) begin
        w = mk(0, cls, 1'b1);
        w[27:24] = 4'(cls); w[4] = b4[0];
        issue(w, 1'b1, st, tr, tw);
        chk(!tr && st == 0, "R1", "word to present slot trapped or stalled", tr, 0);
        if (cls == 14 && b4 == 0) begin exp_cnt[0]++; exp_last[0] = w; end
        w[11:8] = 4'd2;
        issue(w, 1'b1, st, tr, tw);
        chk(tr == (cls == 14 && b4 == 0), "R1", "trap decision on class bits", tr,
            (cls == 14 && b4 == 0));
      end
    end
    settle_and_compare("class");

    // empty mask: every data operation traps (R4)
    cp_present = '0;
    for (int n = 0; n < 16; n++) begin
      w = mk(n, 40 + n, 1'b1);
      issue(w, 1'b1, st, tr, tw);
      chk(tr && tw == w, "R4", "empty mask trap", tw, w);
    end
    settle_and_compare("nomask");

    // drain timing (R8)
    cp_present = 16'hFFFF;
    w = mk(5, 77, 1'b1);
    c0 = cnt_of(5);
    issue(w, 1'b1, st, tr, tw);
    exp_cnt[5]++; exp_last[5] = w;
    chk(cnt_of(5) == c0, "R8", "count after E", cnt_of(5), c0);
    @(negedge clk);
    @(negedge clk);
    chk(cnt_of(5) == c0, "R8", "count after E+2", cnt_of(5), c0);
    @(negedge clk);
    chk(cnt_of(5) == c0 + 1, "R8", "count after E+3", cnt_of(5), c0 + 1);

    // back-to-back burst into one queue (R7)
    repeat (10) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      ws[k] = mk(6, 100 + k, 1'b1);
      exp_cnt[6]++; exp_last[6] = ws[k];
    end
    burst(ws, 8, st);
    chk(st == 6, "R7", "stall cycles over 8-op burst", st, 6);
    settle_and_compare("burst");

    // other queue stays free while one is busy (R10)
    for (int k = 0; k < 4; k++) begin
      ws[k] = mk(9, 120 + k, 1'b1);
      exp_cnt[9]++; exp_last[9] = ws[k];
    end
    ws[4] = mk(10, 130, 1'b1);
    exp_cnt[10]++; exp_last[10] = ws[4];
    burst(ws, 5, st);
    chk(st == 0, "R10", "stall while other queue busy", st, 0);
    settle_and_compare("cross");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule